// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block steps a host processor platform through its power states: fully off, soft-off, suspend-to-RAM and running. Between any two of those levels it passes through a dedicated transition state, so that the order of its outputs is fixed. In each state it reacts to a small set of inputs. These are the always-on rail good flag, the system rail good flag, the two active-low sleep requests from the platform controller, and a power-down acknowledge. From them it drives the resume reset, the system power-ok, the CPU throttle pin, the active-low warm-reset request and an acknowledge back to the SoC.

The five level inputs from the platform pass through two-flop synchronizers. The commands are synchronous, single-cycle and come from the local controller: power-on, forced shutdown and warm reset. So are the throttle request level and the pause-in-soft-off option. All waits are counted in clock cycles, derived from the `CLK_HZ` parameter. These waits are the rail-good timeout, the resume settling delay, the power-ok drop guard and the warm-reset pulse. The block has no data stream, so every pin is a plain control or status level without handshake.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the state is fully-off (code 0). Resume reset and system power-ok are low, the throttle pin is at its inactive level, the warm-reset request is high and the SoC acknowledge is high.
- R2: State codes on `state_o` are: off=0, off→soft-off=1, soft-off=2, soft-off→suspend=3, suspend=4, suspend→run=5, run=6, run→suspend=7, suspend→soft-off=8, soft-off→off=9. A `pwr_on_i` pulse in state 0 moves to state 1 on the next edge and drives the SoC acknowledge low.
- R3: In state 1, a good always-on rail moves to state 2 and releases resume reset (high). If the rail stays bad for `PG_TIMEOUT_MS` (exactly that many milliseconds of cycles in state 1), a forced shutdown is taken and the block returns to state 0 with resume reset low.
- R4: In state 2, a high S4 sleep request moves to state 3, and state 3 moves to state 4 one cycle later. While the request stays low, the block stays in state 2.
- R5: Suspend (4) checks its exits in this priority: loss of the always-on rail forces shutdown and goes to 8, then a high S3 request goes to 5, then a low S4 request goes to 8.
- R6: State 5 stays exactly `RESUME_WAIT_MS` of cycles. It then sets system power-ok high, loads the throttle pin from the throttle request and enters 6. Loss of the always-on rail during the wait forces shutdown and goes to 8.
- R7: In run (6), loss of the always-on rail forces shutdown and goes to 7. Loss of the system rail or a low sleep request goes to 7 without a forced shutdown, so resume reset stays high.
- R8: Leaving 6 clears system power-ok. The throttle pin is released to inactive only after at least 40 ns spent in state 7, and then the block enters 4.
- R9: State 8 goes to 2 when `pause_s5_i` is high and to 9 otherwise.
- R10: In state 9, a pending forced shutdown sets the SoC acknowledge high, clears the pending flag and enters 0. Otherwise a high power-down acknowledge drives resume reset low, sets the SoC acknowledge high and enters 0. With neither present, the block returns to 2.
- R11: A `force_off_i` pulse drives system power-ok and resume reset low on the next edge without changing the state. It also leaves a forced shutdown pending until state 0 is reached.
- R12: A `warm_rst_i` pulse drives `rcin_n_o` low for exactly `WARM_RST_MS` of cycles and then releases it. The power state and system power-ok are untouched.
- R13: The throttle pin follows the throttle request, one edge later, only while in run. Outside run the request is ignored. `THROTTLE_ACTIVE_LOW` inverts the pin's polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | Power-on command pulse |
| force_off_i | input | 1 | Forced-shutdown command pulse |
| warm_rst_i | input | 1 | Warm-reset command pulse |
| throttle_req_i | input | 1 | Throttle request level |
| pause_s5_i | input | 1 | Pause in soft-off on the way down |
| rsm_pg_i | input | 1 | Always-on rail good (asynchronous) |
| sys_pg_i | input | 1 | System rail good (asynchronous) |
| slp_s3_n_i | input | 1 | Active-low S3 sleep request (asynchronous) |
| slp_s4_n_i | input | 1 | Active-low S4 sleep request (asynchronous) |
| pwrdn_ack_i | input | 1 | Suspend power-down acknowledge (asynchronous) |
| rsmrst_n_o | output | 1 | Active-low resume reset |
| sys_pwrok_o | output | 1 | System power-ok |
| prochot_o | output | 1 | CPU throttle pin |
| rcin_n_o | output | 1 | Active-low warm-reset request |
| soc_ack_o | output | 1 | Acknowledge to SoC (high in full off) |
| state_o | output | 4 | Current power state code (see R2) |

## Verification
The five platform inputs reach the state register on the third rising edge after they change: two synchronizer flops, then the state flop. The bench therefore waits three falling edges before it samples the result. The commands and the throttle request act on the very next edge, so their effects are sampled one falling edge later. Timed waits are measured by counting falling-edge samples spent in the state or at the level, and are compared against the exact cycle count: the rail timeout, resume delay and warm pulse. The state sequence is checked by a monitor against a queue that the driver fills before each stimulus, so an extra, missing or reordered transition is caught whatever its latency.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    PS_G3   = 4'd0,
    PS_G3S5 = 4'd1,
    PS_S5   = 4'd2,
    PS_S5S3 = 4'd3,
    PS_S3   = 4'd4,
    PS_S3S0 = 4'd5,
    PS_S0   = 4'd6,
    PS_S0S3 = 4'd7,
    PS_S3S5 = 4'd8,
    PS_S5G3 = 4'd9
  } pwr_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] val_i,
  output logic             done_o
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_wrst.sv
module pwr_seq_wrst #(
  parameter int PULSE_CYC = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rcin_n_o
);

  localparam int TW = $clog2(PULSE_CYC + 1);
  localparam logic [TW-1:0] LD = TW'(PULSE_CYC - 1);

  logic active_q;
  logic tmr_done;
  logic start;

  assign start = req_i && !active_q;

  pwr_seq_timer #(.WIDTH(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .val_i  (LD),
    .done_o (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    active_q <= 1'b0;
    else if (start)                active_q <= 1'b1;
    else if (active_q && tmr_done) active_q <= 1'b0;
  end

  assign rcin_n_o = !active_q;

  logic [TW:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt_q <= '0;
    else if (active_q) low_cnt_q <= low_cnt_q + 1'b1;
    else               low_cnt_q <= '0;
  end

  AST_WARM_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcin_n_o) |-> (low_cnt_q == (TW+1)'(PULSE_CYC))); // R12

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CLK_HZ              = 50_000_000,
  parameter int PG_TIMEOUT_MS       = 100,
  parameter int RESUME_WAIT_MS      = 15,
  parameter bit THROTTLE_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_i,
  input  logic       force_off_i,
  input  logic       throttle_req_i,
  input  logic       pause_s5_i,
  input  logic       rsm_pg_s,
  input  logic       sys_pg_s,
  input  logic       slp_s3_n_s,
  input  logic       slp_s4_n_s,
  input  logic       pwrdn_ack_s,
  output logic       rsmrst_n_o,
  output logic       sys_pwrok_o,
  output logic       prochot_o,
  output logic       soc_ack_o,
  output logic [3:0] state_o
);

  localparam int MS_CYC  = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int PG_CYC  = PG_TIMEOUT_MS * MS_CYC;
  localparam int RES_CYC = RESUME_WAIT_MS * MS_CYC;
  localparam int OFF_CYC = CLK_HZ / 25_000_000 + 1;   // >= 40 ns
  localparam int TW      = $clog2(max3(PG_CYC, RES_CYC, OFF_CYC) + 1);
  localparam logic [TW-1:0] PG_LD  = TW'(PG_CYC - 1);
  localparam logic [TW-1:0] RES_LD = TW'(RES_CYC - 1);
  localparam logic [TW-1:0] OFF_LD = TW'(OFF_CYC - 1);
  localparam logic THR_OFF = THROTTLE_ACTIVE_LOW;

  pwr_state_e state_q, nxt;
  logic rsmrst_n_q, sys_pwrok_q, prochot_q, soc_ack_q, pending_q;
  logic rail_fail, frc, run_ok, thr_lvl;
  logic tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  assign run_ok  = sys_pg_s && slp_s3_n_s && slp_s4_n_s;
  assign thr_lvl = throttle_req_i ^ THROTTLE_ACTIVE_LOW;
  assign frc     = force_off_i || rail_fail;

  pwr_seq_timer #(.WIDTH(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  always_comb begin
    nxt       = state_q;
    rail_fail = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      PS_G3: if (pwr_on_i) begin
        nxt = PS_G3S5; tmr_load = 1'b1; tmr_val = PG_LD;
      end
      PS_G3S5: begin
        if (rsm_pg_s)      nxt = PS_S5;
        else if (tmr_done) begin nxt = PS_G3; rail_fail = 1'b1; end
      end
      PS_S5:   if (slp_s4_n_s) nxt = PS_S5S3;
      PS_S5S3: nxt = PS_S3;
      PS_S3: begin
        if (!rsm_pg_s)        begin nxt = PS_S3S5; rail_fail = 1'b1; end
        else if (slp_s3_n_s)  begin nxt = PS_S3S0; tmr_load = 1'b1; tmr_val = RES_LD; end
        else if (!slp_s4_n_s) nxt = PS_S3S5;
      end
      PS_S3S0: begin
        if (!rsm_pg_s)     begin nxt = PS_S3S5; rail_fail = 1'b1; end
        else if (tmr_done) nxt = PS_S0;
      end
      PS_S0: begin
        if (!rsm_pg_s) begin
          nxt = PS_S0S3; rail_fail = 1'b1; tmr_load = 1'b1; tmr_val = OFF_LD;
        end else if (!run_ok) begin
          nxt = PS_S0S3; tmr_load = 1'b1; tmr_val = OFF_LD;
        end
      end
      PS_S0S3: if (tmr_done) nxt = PS_S3;
      PS_S3S5: nxt = pause_s5_i ? PS_S5 : PS_S5G3;
      PS_S5G3: nxt = (pending_q || pwrdn_ack_s) ? PS_G3 : PS_S5;
      default: nxt = PS_G3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_G3;
      rsmrst_n_q  <= 1'b0;
      sys_pwrok_q <= 1'b0;
      prochot_q   <= THR_OFF;
      soc_ack_q   <= 1'b1;
      pending_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      case (state_q)
        PS_G3:   if (pwr_on_i) soc_ack_q <= 1'b0;
        PS_G3S5: if (rsm_pg_s) rsmrst_n_q <= 1'b1;
        PS_S3S0: if (rsm_pg_s && tmr_done) begin
          prochot_q   <= thr_lvl;
          sys_pwrok_q <= 1'b1;
        end
        PS_S0: begin
          if (nxt == PS_S0) prochot_q   <= thr_lvl;
          else              sys_pwrok_q <= 1'b0;
        end
        PS_S0S3: if (tmr_done) prochot_q <= THR_OFF;
        PS_S5G3: begin
          if (pending_q) soc_ack_q <= 1'b1;
          else if (pwrdn_ack_s) begin
            rsmrst_n_q <= 1'b0;
            soc_ack_q  <= 1'b1;
          end
        end
        default: ;
      endcase
      if (frc) begin
        sys_pwrok_q <= 1'b0;
        rsmrst_n_q  <= 1'b0;
      end
      if (frc)                                           pending_q <= 1'b1;
      else if (state_q == PS_G3 || state_q == PS_S5G3)   pending_q <= 1'b0;
    end
  end

  assign rsmrst_n_o  = rsmrst_n_q;
  assign sys_pwrok_o = sys_pwrok_q;
  assign prochot_o   = prochot_q;
  assign soc_ack_o   = soc_ack_q;
  assign state_o     = state_q;

  logic [TW:0] dwell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dwell_q <= '0;
    else if (state_q == PS_S3S0) dwell_q <= dwell_q + 1'b1;
    else                         dwell_q <= '0;
  end

  AST_PWROK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pwrok_q |-> (state_q == PS_S0)); // R6
  AST_FORCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |=> (!sys_pwrok_q && !rsmrst_n_q)); // R11
  AST_THROTTLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {PS_G3, PS_G3S5, PS_S5, PS_S5S3, PS_S3, PS_S3S0, PS_S3S5, PS_S5G3})
    |-> (prochot_q == THR_OFF)); // R13
  AST_ACK_AT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_G3 && $past(state_q) == PS_S5G3) |-> soc_ack_q); // R10
  AST_RESUME_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_S0 && $past(state_q) == PS_S3S0) |-> (dwell_q == (TW+1)'(RES_CYC))); // R6
  AST_PWROK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_S0S3) |-> !sys_pwrok_q); // R8

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int CLK_HZ              = 50_000_000,
  parameter int PG_TIMEOUT_MS       = 100,
  parameter int RESUME_WAIT_MS      = 15,
  parameter int WARM_RST_MS         = 32,
  parameter int SYNC_STAGES         = 2,
  parameter bit THROTTLE_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_i,
  input  logic       force_off_i,
  input  logic       warm_rst_i,
  input  logic       throttle_req_i,
  input  logic       pause_s5_i,
  input  logic       rsm_pg_i,
  input  logic       sys_pg_i,
  input  logic       slp_s3_n_i,
  input  logic       slp_s4_n_i,
  input  logic       pwrdn_ack_i,
  output logic       rsmrst_n_o,
  output logic       sys_pwrok_o,
  output logic       prochot_o,
  output logic       rcin_n_o,
  output logic       soc_ack_o,
  output logic [3:0] state_o
);

  localparam int MS_CYC   = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int WARM_CYC = WARM_RST_MS * MS_CYC;
  localparam int N_IN     = 5;

  logic [N_IN-1:0] raw, syncd;

  assign raw = {pwrdn_ack_i, slp_s4_n_i, slp_s3_n_i, sys_pg_i, rsm_pg_i};

  pwr_seq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (syncd)
  );

  pwr_seq_fsm #(
    .CLK_HZ              (CLK_HZ),
    .PG_TIMEOUT_MS       (PG_TIMEOUT_MS),
    .RESUME_WAIT_MS      (RESUME_WAIT_MS),
    .THROTTLE_ACTIVE_LOW (THROTTLE_ACTIVE_LOW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_on_i       (pwr_on_i),
    .force_off_i    (force_off_i),
    .throttle_req_i (throttle_req_i),
    .pause_s5_i     (pause_s5_i),
    .rsm_pg_s       (syncd[0]),
    .sys_pg_s       (syncd[1]),
    .slp_s3_n_s     (syncd[2]),
    .slp_s4_n_s     (syncd[3]),
    .pwrdn_ack_s    (syncd[4]),
    .rsmrst_n_o     (rsmrst_n_o),
    .sys_pwrok_o    (sys_pwrok_o),
    .prochot_o      (prochot_o),
    .soc_ack_o      (soc_ack_o),
    .state_o        (state_o)
  );

  pwr_seq_wrst #(.PULSE_CYC(WARM_CYC)) u_wrst (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (warm_rst_i),
    .rcin_n_o (rcin_n_o)
  );

endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;

  localparam int CLK_HZ   = 10_000;  // scaled: 10 cycles per ms
  localparam int PG_CYC   = 1000;
  localparam int RES_CYC  = 150;
  localparam int WARM_CYC = 320;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, pwr_on, force_off, warm_rst, throttle_req, pause_s5;
  logic rsm_pg, sys_pg, slp_s3_n, slp_s4_n, pwrdn_ack;
  logic rsmrst_n, sys_pwrok, prochot, rcin_n, soc_ack;
  logic [3:0] state;

  pwr_seq_top #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .force_off_i(force_off),
    .warm_rst_i(warm_rst), .throttle_req_i(throttle_req), .pause_s5_i(pause_s5),
    .rsm_pg_i(rsm_pg), .sys_pg_i(sys_pg), .slp_s3_n_i(slp_s3_n),
    .slp_s4_n_i(slp_s4_n), .pwrdn_ack_i(pwrdn_ack),
    .rsmrst_n_o(rsmrst_n), .sys_pwrok_o(sys_pwrok), .prochot_o(prochot),
    .rcin_n_o(rcin_n), .soc_ack_o(soc_ack), .state_o(state)
  );

  int vectors = 0;
  int miscompares = 0;
  bit reported = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] s, input string req);
    exp_q.push_back(s);
    tag_q.push_back(req);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [3:0] st, input int limit, input string req);
    int n = 0;
    while (state !== st && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(req, "reach state", state, st);
  endtask

  task automatic pulse_on();
    pwr_on = 1'b1;
    @(negedge clk);
    pwr_on = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  // Monitor: every state change is compared with the driver's queue.
  initial begin
    logic [3:0] prev;
    @(posedge rst_n);
    @(negedge clk);
    prev = state;
    forever begin
      @(negedge clk);
      if (state !== prev) begin
        if (exp_q.size() == 0) check("SEQ", "unexpected state", state, 4'hF);
        else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, "state order", state, e);
        end
        prev = state;
      end
    end
  end

  initial begin
    repeat (100_000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; pwr_on = 1'b0; force_off = 1'b0; warm_rst = 1'b0;
    throttle_req = 1'b0; pause_s5 = 1'b0; rsm_pg = 1'b0; sys_pg = 1'b0;
    slp_s3_n = 1'b0; slp_s4_n = 1'b0; pwrdn_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    check("R1", "state", state, 0);
    check("R1", "rsmrst_n", rsmrst_n, 0);
    check("R1", "sys_pwrok", sys_pwrok, 0);
    check("R1", "prochot", prochot, 0);
    check("R1", "rcin_n", rcin_n, 1);
    check("R1", "soc_ack", soc_ack, 1);

    // R2 / R3 timeout path: rail never good
    push(1, "R2"); push(0, "R3");
    pulse_on();
    check("R2", "state after power-on", state, 1);
    check("R2", "soc_ack low", soc_ack, 0);
    n = 0;
    while (state == 4'd1 && n < 5000) begin n++; @(negedge clk); end
    check("R3", "timeout dwell", n, PG_CYC);
    check("R3", "rsmrst_n after timeout", rsmrst_n, 0);

    // R3 good rail path, R4 soft-off hold and climb
    rsm_pg = 1'b1; tick(4);
    push(1, "R3"); push(2, "R3");
    pulse_on();
    @(negedge clk);
    check("R3", "state soft-off", state, 2);
    check("R3", "rsmrst_n released", rsmrst_n, 1);
    tick(5);
    check("R4", "hold in soft-off", state, 2);
    push(3, "R4"); push(4, "R4");
    slp_s4_n = 1'b1;
    tick(3);
    check("R4", "soft-off to suspend transit", state, 3);
    tick(1);
    check("R4", "suspend", state, 4);

    // R13 request ignored outside run
    throttle_req = 1'b1; tick(3);
    check("R13", "prochot in suspend", prochot, 0);

    // R6 resume wait
    sys_pg = 1'b1; tick(3);
    push(5, "R5"); push(6, "R6");
    slp_s3_n = 1'b1;
    tick(3);
    check("R5", "suspend to resume transit", state, 5);
    n = 0;
    while (state == 4'd5 && n < 5000) begin n++; @(negedge clk); end
    check("R6", "resume dwell", n, RES_CYC);
    check("R6", "sys_pwrok", sys_pwrok, 1);
    check("R6", "prochot loaded", prochot, 1);

    // R13 follows in run
    throttle_req = 1'b0; @(negedge clk);
    check("R13", "prochot follows low", prochot, 0);
    throttle_req = 1'b1; @(negedge clk);
    check("R13", "prochot follows high", prochot, 1);

    // R12 warm reset
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    check("R12", "rcin_n low", rcin_n, 0);
    n = 1;
    while (rcin_n == 1'b0 && n < 5000) begin @(negedge clk); if (rcin_n == 1'b0) n++; end
    check("R12", "warm pulse length", n, WARM_CYC);
    check("R12", "state untouched", state, 6);
    check("R12", "sys_pwrok untouched", sys_pwrok, 1);

    // R7 non-forced exit, R8 drop order
    push(7, "R7"); push(4, "R8");
    slp_s3_n = 1'b0;
    tick(3);
    check("R8", "run to suspend transit", state, 7);
    check("R8", "sys_pwrok cleared", sys_pwrok, 0);
    check("R8", "prochot held in transit", prochot, 1);
    tick(1);
    check("R8", "suspend", state, 4);
    check("R8", "prochot released", prochot, 0);
    check("R7", "rsmrst_n kept high", rsmrst_n, 1);

    // R6 rail loss during resume wait, R10 pending path
    push(5, "R6"); push(8, "R6"); push(9, "R10"); push(0, "R10");
    slp_s3_n = 1'b1; tick(3);
    check("R6", "resume transit", state, 5);
    tick(10);
    rsm_pg = 1'b0; tick(3);
    check("R6", "abort to suspend-off transit", state, 8);
    check("R6", "rsmrst_n forced low", rsmrst_n, 0);
    tick(2);
    check("R10", "off via pending", state, 0);
    check("R10", "soc_ack high", soc_ack, 1);

    // R7 rail loss in run, R5 rail loss in suspend
    rsm_pg = 1'b1; tick(3);
    push(1, "R2"); push(2, "R3"); push(3, "R4"); push(4, "R4"); push(5, "R5"); push(6, "R6");
    pulse_on();
    wait_state(6, 400, "R6");
    push(7, "R7"); push(4, "R5"); push(8, "R5"); push(9, "R9"); push(0, "R10");
    rsm_pg = 1'b0; tick(3);
    check("R7", "forced exit transit", state, 7);
    check("R7", "rsmrst_n forced", rsmrst_n, 0);
    check("R7", "sys_pwrok cleared", sys_pwrok, 0);
    wait_state(0, 20, "R5");
    check("R10", "soc_ack after rail loss", soc_ack, 1);

    // R9 pause in soft-off; R10 fallback and acknowledge handshake
    rsm_pg = 1'b1; slp_s3_n = 1'b0; slp_s4_n = 1'b0; tick(3);
    push(1, "R2"); push(2, "R3");
    pulse_on();
    wait_state(2, 10, "R3");
    tick(3);
    check("R4", "stays in soft-off", state, 2);
    push(3, "R4"); push(4, "R4");
    slp_s4_n = 1'b1;
    wait_state(4, 10, "R4");
    pause_s5 = 1'b1;
    push(8, "R5"); push(2, "R9");
    slp_s4_n = 1'b0;
    wait_state(2, 10, "R9");
    check("R9", "rsmrst_n kept when paused", rsmrst_n, 1);
    pause_s5 = 1'b0;
    push(3, "R4"); push(4, "R4");
    slp_s4_n = 1'b1;
    wait_state(4, 10, "R4");
    push(8, "R9"); push(9, "R9"); push(2, "R10");
    slp_s4_n = 1'b0;
    wait_state(9, 10, "R9");
    wait_state(2, 10, "R10");
    check("R10", "rsmrst_n without ack", rsmrst_n, 1);
    check("R10", "soc_ack without ack", soc_ack, 0);
    pwrdn_ack = 1'b1; tick(3);
    push(3, "R4"); push(4, "R4");
    slp_s4_n = 1'b1;
    wait_state(4, 10, "R4");
    push(8, "R5"); push(9, "R9"); push(0, "R10");
    slp_s4_n = 1'b0;
    wait_state(0, 10, "R10");
    check("R10", "rsmrst_n asserted on ack", rsmrst_n, 0);
    check("R10", "soc_ack on ack", soc_ack, 1);

    // R11 forced-shutdown command in run
    pwrdn_ack = 1'b0; slp_s3_n = 1'b1; slp_s4_n = 1'b1; tick(3);
    push(1, "R2"); push(2, "R3"); push(3, "R4"); push(4, "R4"); push(5, "R5"); push(6, "R6");
    pulse_on();
    wait_state(6, 400, "R6");
    check("R6", "sys_pwrok in run", sys_pwrok, 1);
    force_off = 1'b1; @(negedge clk); force_off = 1'b0;
    check("R11", "sys_pwrok dropped", sys_pwrok, 0);
    check("R11", "rsmrst_n dropped", rsmrst_n, 0);
    check("R11", "state unchanged", state, 6);
    push(7, "R7"); push(4, "R8"); push(8, "R5"); push(9, "R9"); push(0, "R11");
    slp_s3_n = 1'b0; slp_s4_n = 1'b0;
    wait_state(0, 20, "R11");
    check("R11", "soc_ack via pending", soc_ack, 1);

    tick(2);
    check("SEQ", "pending expectations", exp_q.size(), 0);
    report();
    $finish;
  end

endmodule